// File: doc/BRIEF.md
# Link Pointer Entry Validator

This block runs the part of the virtual-machine entry checks that covers the link pointer of the control structure. When the access-shadowing control is on, it also checks the two access-bitmap addresses. A single-cycle `start` pulse captures a snapshot of all operands. The block then checks them in a fixed order and, if the pointer is usable, reads the 32-bit revision word stored at the link pointer through a simple request/response memory port. It ends the run with a one-cycle verdict that carries a pass flag, a failure class and a qualification code.

A link pointer of all ones means that no linked structure is present. In that case the pointer checks and the memory read are skipped. Any other link pointer must be page aligned and must fit the physical address width given on `pa_width`. Its revision word must carry the expected revision, with a shadow marker that is required when shadowing is on. The pointer must also not alias the structure that is currently active. Which structure counts as active depends on the system-management mode.

Top module: `lpv_link_validator`

## Requirements
- R1: After reset `res_valid` and `mem_req_valid` are 0, and they stay 0 until a `start` is accepted.
- R2: With `shadow_en`=1, a read-bitmap or write-bitmap address is rejected if it has any of bits [11:0] set, or any bit at or above `pa_width` set. A rejected address ends the run with `res_class`=1 (control-field error), `res_pass`=0 and `res_qual`=0, and no memory read is made.
- R3: With `shadow_en`=0, the values on the two bitmap addresses have no effect on the verdict.
- R4: A `link_ptr` of all ones, once the bitmap checks have passed, ends the run with `res_pass`=1 and `res_class`=0, and no memory read is made.
- R5: A link pointer other than all ones is rejected if it has any of bits [11:0] set, or any bit at or above `pa_width` set. A rejected pointer ends the run with `res_class`=2 (guest-state error), `res_qual`=QUAL_LINK (default 4), and no memory read is made.
- R6: A link pointer that passes R5 causes exactly one read request, with `mem_req_addr` equal to `link_ptr`. The request is held with a stable address until `mem_req_ready` is seen, and the word arriving with `mem_rsp_valid` is used as the revision word.
- R7: With `shadow_en`=1, a revision word whose bit 31 is 0 is rejected with `res_class`=2.
- R8: With `shadow_en`=1, bit 31 is cleared and the rest of the word must equal REV_ID. With `shadow_en`=0, the whole word must equal REV_ID, so a word with bit 31 set fails. Any mismatch gives `res_class`=2.
- R9: When `in_smm`=0 or `smm_entry`=1, a `link_ptr` equal to `cur_ptr` gives `res_class`=2. When `in_smm`=1 and `smm_entry`=0, a `link_ptr` equal to `root_ptr` gives `res_class`=2 and equality with `cur_ptr` is allowed.
- R10: The checks run in this order: bitmap addresses, link alignment and width, revision, pointer compare. Only the first failure is reported, so a bitmap failure hides a bad link pointer.
- R11: Every accepted `start` produces exactly one `res_valid` pulse, one cycle long. In that cycle `res_pass`=1 exactly when `res_class`=0, and `res_qual` is nonzero only when `res_class`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a validation; operands are captured in this cycle if the block is idle |
| shadow_en | input | 1 | Access-shadowing control |
| rd_bmp_addr | input | ADDR_W | Read-bitmap address |
| wr_bmp_addr | input | ADDR_W | Write-bitmap address |
| link_ptr | input | ADDR_W | Link pointer under test |
| cur_ptr | input | ADDR_W | Pointer of the currently active structure |
| root_ptr | input | ADDR_W | Pointer of the root-mode region |
| in_smm | input | 1 | Processor is in system-management mode |
| smm_entry | input | 1 | This entry enters system-management mode |
| pa_width | input | PW_W | Number of valid physical address bits |
| mem_req_valid | output | 1 | Revision word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Revision word |
| res_valid | output | 1 | Verdict pulse |
| res_pass | output | 1 | Entry checks passed |
| res_class | output | 2 | 0 none, 1 control-field error, 2 guest-state error |
| res_qual | output | 8 | Qualification code, QUAL_LINK on a guest-state failure |

## Verification
A bitmap failure and a link-pointer failure can both be present in the same run. The bench provokes this by driving a misaligned read-bitmap address together with a misaligned link pointer. It judges the result by expecting a control-field class, zero qualification and no memory read. A second collision puts a revision mismatch and a pointer alias in one run, and only the guest-state class with one read must appear. The memory responder delays `mem_req_ready` by several cycles, so the request-hold rule is exercised as well.

// File: rtl/lpv_pkg.sv
// Shared types of the link pointer validator.
package lpv_pkg;
    typedef enum logic [1:0] {
        FC_NONE  = 2'd0,
        FC_CTRL  = 2'd1,
        FC_GUEST = 2'd2
    } fail_class_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_REQ   = 3'd2,
        ST_WAIT  = 3'd3,
        ST_EVAL  = 3'd4
    } lpv_state_e;
endpackage

// File: rtl/lpv_addr_check.sv
// Address legality check: the address must sit on a page boundary and fit
// within pa_width physical bits. Purely combinational; assumes pa_width is
// the count of implemented physical bits.
module lpv_addr_check #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int PW_W      = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PW_W-1:0]   pa_width,
    output logic              ok
);
    logic aligned;
    logic fits;

    // Alignment and width tests combined into one legality flag.
    always_comb begin
        aligned = (addr[PAGE_BITS-1:0] == '0);
        fits    = ((addr >> pa_width) == '0);
        ok      = aligned && fits;
    end
endmodule

// File: rtl/lpv_rev_check.sv
// Revision word check. With shadowing on, the marker bit must be set and is
// cleared before the compare; with shadowing off, the word must match exactly.
module lpv_rev_check #(
    parameter logic [31:0] REV_ID     = 32'h0000_2A1F,
    parameter int          SHADOW_BIT = 31
) (
    input  logic [31:0] word,
    input  logic        shadow_en,
    output logic        bad
);
    logic [31:0] stripped;

    // Strip the marker and decide whether the revision is acceptable.
    always_comb begin
        stripped             = word;
        stripped[SHADOW_BIT] = 1'b0;
        if (shadow_en)
            bad = !word[SHADOW_BIT] || (stripped != REV_ID);
        else
            bad = (word != REV_ID);
    end
endmodule

// File: rtl/lpv_ptr_compare.sv
// Alias check of the link pointer against the pointer that is active in the
// current mode: the current structure outside SMM or when entering SMM,
// the root-mode region pointer otherwise.
module lpv_ptr_compare #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] link,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] root,
    input  logic              in_smm,
    input  logic              smm_entry,
    output logic              bad
);
    logic [ADDR_W-1:0] other;

    // Choose the reference pointer and flag equality.
    always_comb begin
        other = (!in_smm || smm_entry) ? cur : root;
        bad   = (link == other);
    end
endmodule

// File: rtl/lpv_seq.sv
// Check sequencer: walks bitmap, link legality, revision fetch and
// evaluation in a fixed order and issues a one-cycle verdict. Assumes the
// memory returns exactly one response per accepted request.
module lpv_seq
    import lpv_pkg::*;
#(
    parameter logic [7:0] QUAL_LINK = 8'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        bmp_fail,
    input  logic        link_none,
    input  logic        link_bad,
    input  logic        rev_bad,
    input  logic        ptr_bad,
    output logic        accept,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic [31:0] rev_q,
    output logic        res_valid,
    output logic        res_pass,
    output logic [1:0]  res_class,
    output logic [7:0]  res_qual
);
    lpv_state_e  state;
    logic        fin;
    fail_class_e fin_class;

    assign accept        = start && (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);

    // Decide whether this cycle ends the run, and with which class.
    always_comb begin
        fin       = 1'b0;
        fin_class = FC_NONE;
        case (state)
            ST_CHECK: begin
                if (bmp_fail) begin
                    fin = 1'b1; fin_class = FC_CTRL;
                end else if (link_none) begin
                    fin = 1'b1; fin_class = FC_NONE;
                end else if (link_bad) begin
                    fin = 1'b1; fin_class = FC_GUEST;
                end
            end
            ST_EVAL: begin
                fin       = 1'b1;
                fin_class = (rev_bad || ptr_bad) ? FC_GUEST : FC_NONE;
            end
            default: ;
        endcase
    end

    // State register, revision capture and registered verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rev_q     <= '0;
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_class <= FC_NONE;
            res_qual  <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE:  if (start) state <= ST_CHECK;
                ST_CHECK: if (!fin) state <= ST_REQ;
                ST_REQ:   if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rev_q <= mem_rsp_data;
                        state <= ST_EVAL;
                    end
                end
                default: ;
            endcase
            if (fin) begin
                state     <= ST_IDLE;
                res_valid <= 1'b1;
                res_pass  <= (fin_class == FC_NONE);
                res_class <= fin_class;
                res_qual  <= (fin_class == FC_GUEST) ? QUAL_LINK : 8'd0;
            end
        end
    end

    // R6: a pending request stays up until accepted.
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid);

    // R11: the verdict is a single-cycle pulse.
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11: pass flag agrees with the class; qualification only on guest class.
    a_r11_pass_class: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass == (res_class == FC_NONE)) &&
                      ((res_qual != 8'd0) == (res_class == FC_GUEST)));
endmodule

// File: rtl/lpv_link_validator.sv
// Top of the link pointer entry validator. Captures the operands on an
// accepted start, runs the three address legality checks from one generate
// loop, and feeds the sequencer with the individual check results.
module lpv_link_validator
    import lpv_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          PAGE_BITS  = 12,
    parameter int          PW_W       = $clog2(ADDR_W + 1),
    parameter logic [31:0] REV_ID     = 32'h0000_2A1F,
    parameter int          SHADOW_BIT = 31,
    parameter logic [7:0]  QUAL_LINK  = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shadow_en,
    input  logic [ADDR_W-1:0] rd_bmp_addr,
    input  logic [ADDR_W-1:0] wr_bmp_addr,
    input  logic [ADDR_W-1:0] link_ptr,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] root_ptr,
    input  logic              in_smm,
    input  logic              smm_entry,
    input  logic [PW_W-1:0]   pa_width,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              res_valid,
    output logic              res_pass,
    output logic [1:0]        res_class,
    output logic [7:0]        res_qual
);
    localparam int N_ADDR = 3;

    logic              accept;
    logic              shadow_q, smm_q, smme_q;
    logic [ADDR_W-1:0] addr_q [N_ADDR];
    logic [ADDR_W-1:0] cur_q, root_q;
    logic [PW_W-1:0]   pa_q;
    logic [N_ADDR-1:0] addr_ok;
    logic [31:0]       rev_q;
    logic              bmp_fail, link_none, rev_bad, ptr_bad;

    // Operand snapshot taken when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= 1'b0;
            smm_q    <= 1'b0;
            smme_q   <= 1'b0;
            cur_q    <= '0;
            root_q   <= '0;
            pa_q     <= '0;
            for (int i = 0; i < N_ADDR; i++) addr_q[i] <= '0;
        end else if (accept) begin
            shadow_q  <= shadow_en;
            smm_q     <= in_smm;
            smme_q    <= smm_entry;
            cur_q     <= cur_ptr;
            root_q    <= root_ptr;
            pa_q      <= pa_width;
            addr_q[0] <= rd_bmp_addr;
            addr_q[1] <= wr_bmp_addr;
            addr_q[2] <= link_ptr;
        end
    end

    // One legality checker per captured address: read bitmap, write bitmap, link.
    for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
        lpv_addr_check #(
            .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PW_W(PW_W)
        ) u_chk (
            .addr(addr_q[g]), .pa_width(pa_q), .ok(addr_ok[g])
        );
    end

    assign bmp_fail     = shadow_q && !(addr_ok[0] && addr_ok[1]);
    assign link_none    = (addr_q[2] == '1);
    assign mem_req_addr = addr_q[2];

    lpv_rev_check #(.REV_ID(REV_ID), .SHADOW_BIT(SHADOW_BIT)) u_rev (
        .word(rev_q), .shadow_en(shadow_q), .bad(rev_bad)
    );

    lpv_ptr_compare #(.ADDR_W(ADDR_W)) u_ptr (
        .link(addr_q[2]), .cur(cur_q), .root(root_q),
        .in_smm(smm_q), .smm_entry(smme_q), .bad(ptr_bad)
    );

    lpv_seq #(.QUAL_LINK(QUAL_LINK)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bmp_fail(bmp_fail), .link_none(link_none), .link_bad(!addr_ok[2]),
        .rev_bad(rev_bad), .ptr_bad(ptr_bad), .accept(accept),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rev_q(rev_q), .res_valid(res_valid), .res_pass(res_pass),
        .res_class(res_class), .res_qual(res_qual)
    );

    // R5: a read is only issued for a page-aligned address inside the width.
    a_r5_req_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[PAGE_BITS-1:0] == '0) &&
                          ((mem_req_addr >> pa_q) == '0));

    // R4: an absent link pointer never produces a read.
    a_r4_none_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr != '1));

    // R6: the request address does not move while the request waits.
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));

    // R2: a control-field verdict only appears with shadowing on.
    a_r2_ctrl_needs_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_class == FC_CTRL) |-> shadow_q);
endmodule

// File: tb/lpv_link_validator_test.sv
module lpv_link_validator_test;
    localparam int          AW   = 64;
    localparam logic [31:0] REV  = 32'h0000_2A1F;
    localparam logic [31:0] MARK = 32'h8000_0000;
    localparam logic [63:0] NONE = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic shadow_en = 1'b0;
    logic [AW-1:0] rd_bmp_addr = '0, wr_bmp_addr = '0, link_ptr = '0;
    logic [AW-1:0] cur_ptr = '0, root_ptr = '0;
    logic in_smm = 1'b0, smm_entry = 1'b0;
    logic [6:0] pa_width = 7'd40;
    logic mem_req_valid, mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic res_valid, res_pass;
    logic [1:0] res_class;
    logic [7:0] res_qual;

    int total = 0, bad = 0;
    int done_cnt = 0, fetch_cnt = 0, fetch_base = 0;
    int lat = 0;
    logic [31:0] mem_word = '0;
    bit finished = 0;

    typedef struct packed {
        logic       pass;
        logic [1:0] cls;
        logic [7:0] qual;
        logic [7:0] fetches;
        logic [63:0] addr;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    always #5 clk = ~clk;

    lpv_link_validator uut (
        .clk(clk), .rst_n(rst_n), .start(start), .shadow_en(shadow_en),
        .rd_bmp_addr(rd_bmp_addr), .wr_bmp_addr(wr_bmp_addr), .link_ptr(link_ptr),
        .cur_ptr(cur_ptr), .root_ptr(root_ptr), .in_smm(in_smm), .smm_entry(smm_entry),
        .pa_width(pa_width), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_pass(res_pass),
        .res_class(res_class), .res_qual(res_qual)
    );

    // Memory responder: delayed ready, then a response two cycles later.
    logic [63:0] last_addr = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (lat) @(negedge clk);
                mem_req_ready = 1'b1;
                last_addr = mem_req_addr;
                fetch_cnt = fetch_cnt + 1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (2) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Monitor: pop the expected verdict and compare at every result pulse.
    always @(negedge clk) begin
        if (res_valid) begin
            exp_t  e;
            string t;
            int    nf;
            if (expq.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected verdict act=1 exp=0");
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                nf = fetch_cnt - fetch_base;
                fetch_base = fetch_cnt;
                total++;
                if (res_pass !== e.pass || res_class !== e.cls || res_qual !== e.qual ||
                    nf != int'(e.fetches)) begin
                    bad++;
                    $display("FAIL %s pass/class/qual/fetch act=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/%0d",
                             t, res_pass, res_class, res_qual, nf,
                             e.pass, e.cls, e.qual, e.fetches);
                end
                if (e.fetches != 0) begin
                    total++;
                    if (last_addr !== e.addr) begin
                        bad++;
                        $display("FAIL R6 read address act=%h exp=%h", last_addr, e.addr);
                    end
                end
            end
            done_cnt++;
        end
    end

    task automatic run(input string tag, input bit sh, input logic [63:0] rd,
                       input logic [63:0] wr, input logic [63:0] lk,
                       input logic [63:0] cu, input logic [63:0] ro,
                       input bit smm, input bit smme, input int pa,
                       input logic [31:0] word, input int cls, input int nfetch);
        exp_t e;
        int   seen;
        @(negedge clk);
        shadow_en = sh; rd_bmp_addr = rd; wr_bmp_addr = wr; link_ptr = lk;
        cur_ptr = cu; root_ptr = ro; in_smm = smm; smm_entry = smme;
        pa_width = 7'(pa); mem_word = word;
        e.pass    = (cls == 0);
        e.cls     = 2'(cls);
        e.qual    = (cls == 2) ? 8'd4 : 8'd0;
        e.fetches = 8'(nfetch);
        e.addr    = lk;
        expq.push_back(e);
        tagq.push_back(tag);
        seen  = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Scramble operands after capture; the snapshot must be used.
        link_ptr = 64'h5; cur_ptr = 64'h7;
        while (done_cnt == seen) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [63:0] GOOD  = 64'h0000_0012_3456_7000;
    localparam logic [63:0] BMP   = 64'h0000_0000_0040_0000;
    localparam logic [63:0] CUR   = 64'h0000_0000_0088_0000;
    localparam logic [63:0] ROOT  = 64'h0000_0000_0099_0000;

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs in reset.
        total++;
        if (res_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
            bad++; $display("FAIL R1 reset outputs act=%b%b exp=00", res_valid, mem_req_valid);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        total++;
        if (res_valid !== 1'b0 || mem_req_valid !== 1'b0) begin
            bad++; $display("FAIL R1 idle outputs act=%b%b exp=00", res_valid, mem_req_valid);
        end

        // R2 / R10: misaligned read bitmap plus misaligned link -> control error only.
        run("R2 R10 bitmap over link", 1, BMP | 64'h10, BMP, 64'h800, CUR, ROOT, 0, 0, 40, REV | MARK, 1, 0);
        // R2: write bitmap beyond physical width.
        run("R2 write bitmap width", 1, BMP, BMP | (64'h1 << 45), GOOD, CUR, ROOT, 0, 0, 40, REV | MARK, 1, 0);
        // R3: bad bitmaps ignored without shadowing.
        run("R3 bitmaps ignored", 0, 64'h3, 64'h1 << 50, NONE, CUR, ROOT, 0, 0, 40, REV, 0, 0);
        run("R3 bitmaps ignored fetch", 0, 64'h3, 64'h1, GOOD, CUR, ROOT, 0, 0, 40, REV, 0, 1);
        // R4: absent link pointer.
        run("R4 no link", 1, BMP, BMP, NONE, CUR, ROOT, 0, 0, 40, 32'h0, 0, 0);
        // R5: misaligned and too-wide link pointer.
        run("R5 link misaligned", 0, BMP, BMP, 64'h1000_0800, CUR, ROOT, 0, 0, 40, REV, 2, 0);
        run("R5 link too wide", 0, BMP, BMP, 64'h1 << 41, CUR, ROOT, 0, 0, 40, REV, 2, 0);
        run("R5 wider space ok", 0, BMP, BMP, 64'h1 << 45, CUR, ROOT, 0, 0, 52, REV, 0, 1);
        // R6 / R8: shadow marker present, slow ready.
        lat = 3;
        run("R6 R8 shadow pass", 1, BMP, BMP, GOOD, CUR, ROOT, 0, 0, 40, REV | MARK, 0, 1);
        lat = 0;
        // R7: marker missing.
        run("R7 marker missing", 1, BMP, BMP, GOOD, CUR, ROOT, 0, 0, 40, REV, 2, 1);
        // R8: shadowing off, exact match required.
        run("R8 plain pass", 0, BMP, BMP, GOOD, CUR, ROOT, 0, 0, 40, REV, 0, 1);
        run("R8 plain marker fails", 0, BMP, BMP, GOOD, CUR, ROOT, 0, 0, 40, REV | MARK, 2, 1);
        run("R8 shadow wrong rev", 1, BMP, BMP, GOOD, CUR, ROOT, 0, 0, 40, (REV ^ 32'h1) | MARK, 2, 1);
        // R9: pointer alias rules.
        run("R9 alias cur", 0, BMP, BMP, CUR, CUR, ROOT, 0, 0, 40, REV, 2, 1);
        run("R9 alias cur smm entry", 0, BMP, BMP, CUR, CUR, ROOT, 1, 1, 40, REV, 2, 1);
        run("R9 cur allowed in smm", 0, BMP, BMP, CUR, CUR, ROOT, 1, 0, 40, REV, 0, 1);
        run("R9 alias root in smm", 0, BMP, BMP, ROOT, CUR, ROOT, 1, 0, 40, REV, 2, 1);
        run("R9 root allowed outside", 0, BMP, BMP, ROOT, CUR, ROOT, 0, 0, 40, REV, 0, 1);
        // R10 / R11: revision and alias failures together -> one guest verdict.
        lat = 1;
        run("R10 R11 rev and alias", 1, BMP, BMP, CUR, CUR, ROOT, 0, 0, 40, REV, 2, 1);

        repeat (5) @(negedge clk);
        total++;
        if (expq.size() != 0) begin
            bad++; $display("FAIL R11 missing verdicts act=%0d exp=0", expq.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule